// File: doc/BRIEF.md
# Fetch-Boundary Interrupt Injector

This block sits on the instruction stream between the fetch unit and the decoder of a small 20-bit stack processor. Three coprocessor request lines feed a set of sticky cause flags. Whenever a fetched word is handed to the decoder while a cause flag is set and no earlier interrupt is still being serviced, the fetched word is dropped. In its place the decoder receives a call to address zero of the home page, and a strobe tells the return-stack logic to push the current program address.

The handler reads the cause flags through a small register port. It acknowledges with one write, and the low address bits of that write pick the sources to clear. Only the first write after an injection counts. Later writes are ignored until the next injection.

The instruction stream uses valid/ready on both sides. The block is combinational pass-through for the handshake: `fetch_ready` follows `out_ready` and `out_valid` follows `fetch_valid`. A word moves on a cycle where `fetch_valid` and `out_ready` are both high. Upstream must hold `fetched_word` and `fetch_valid` steady while stalled. The block in turn holds its substitution choice for the whole stall, so `out_word` stays steady until the word is accepted.

Top module: `irq_inject_ctrl`

## Requirements
- R1: After reset all cause flags are zero, no interrupt is in service, `injected` is low and `rdata` reads zero.
- R2: With no flag set, or with an interrupt in service, `out_word` equals `fetched_word`, `out_valid` equals `fetch_valid` and `fetch_ready` equals `out_ready`.
- R3: A high level on `irq[n]` at a clock edge sets cause flag n from the next cycle, and the flag stays set until it is cleared by an acknowledge. While `rd` is high, `rdata[n]` shows flag n. While `rd` is low, `rdata` is zero.
- R4: On a handshake where some flag is set and no interrupt is in service, `out_word` is the call word and `injected` is high in that cycle. The call word has opcode 5'b11010 in bits 19:15 and zero in the 15-bit target field, bits 14:0, giving 20'hD0000.
- R5: Injection is decided only at a fetch handshake. A pending flag with no accepted fetch never raises `injected`.
- R6: After an injection, accepted fetches pass through unchanged until the acknowledge write.
- R7: The first `wr` after an injection is the acknowledge. It clears flag n where `addr[n]` is 1, leaves the other flags unchanged and ends the in-service state.
- R8: A write made while no interrupt is in service has no effect on the flags. This includes a second write after an acknowledge.
- R9: If `irq[n]` is high on the cycle that clears flag n, the flag is still set afterwards.
- R10: The first accepted fetch after an acknowledge is replaced again if any flag is still set.
- R11: During a stall (`fetch_valid` high, `out_ready` low), the replace/pass choice made in the first stalled cycle holds until the word is accepted. A request arriving during the stall does not change `out_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Fetched word available |
| fetch_ready | output | 1 | Block accepts the fetched word |
| fetched_word | input | 20 | Instruction word from fetch |
| out_valid | output | 1 | Word offered to the decoder |
| out_ready | input | 1 | Decoder accepts the word |
| out_word | output | 20 | Fetched word or injected call |
| injected | output | 1 | Call injected on this handshake; push return address |
| irq | input | 3 | Level request per source |
| addr | input | 3 | Write address bits; bit n selects source n for clearing |
| wr | input | 1 | Write strobe to the cause register |
| rd | input | 1 | Read strobe to the cause register |
| rdata | output | 3 | Cause flags, bit n for source n |

## Verification
Two things can land in the same cycle: the acknowledge clearing a flag, and that same source still requesting. The bench sweeps every request pattern against every clear mask, and checks the flags that remain against the pattern with the mask bits removed. It then drives the source's request high in the very cycle of the acknowledge and expects the flag to survive. A second collision, an acknowledge write on the same cycle as an accepted fetch, must pass the word through and inject on the next fetch.

// File: rtl/irq_inject_pkg.sv
package irq_inject_pkg;

  localparam int WORD_W_DEF = 20;
  localparam int OP_W_DEF   = 5;
  localparam int NSRC_DEF   = 3;

  // Build the substitute call word: opcode on top, target field zero
  function automatic logic [WORD_W_DEF-1:0] call_word(input logic [OP_W_DEF-1:0] op);
    call_word = {op, {(WORD_W_DEF-OP_W_DEF){1'b0}}};
  endfunction

endpackage

// File: rtl/irq_cause_reg.sv
module irq_cause_reg #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq,
  input  logic            ack_fire,
  input  logic [NSRC-1:0] ack_mask,
  input  logic            rd,
  output logic [NSRC-1:0] rdata,
  output logic            pending
);

  logic [NSRC-1:0] flags_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic clr;
    assign clr = ack_fire & ack_mask[i];

    always_ff @(posedge clk) begin
      if (!rst_n) flags_q[i] <= 1'b0;
      else        flags_q[i] <= (flags_q[i] & ~clr) | irq[i];
    end

    // R3
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flags_q[i] && !(ack_fire && ack_mask[i]) |=> flags_q[i]);

    // R9
    req_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] |=> flags_q[i]);
  end

  assign pending = |flags_q;
  assign rdata   = rd ? flags_q : '0;

endmodule

// File: rtl/irq_fetch_gate.sv
module irq_fetch_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic fetch_valid,
  input  logic out_ready,
  input  logic pending,
  input  logic wr,
  output logic sel,
  output logic injected,
  output logic ack_fire
);

  logic in_svc_q;
  logic locked_q;
  logic hold_q;
  logic xfer;

  assign xfer     = fetch_valid & out_ready;
  assign sel      = locked_q ? hold_q : (pending & ~in_svc_q);
  assign injected = xfer & sel;
  assign ack_fire = wr & in_svc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_svc_q <= 1'b0;
      locked_q <= 1'b0;
      hold_q   <= 1'b0;
    end else begin
      locked_q <= fetch_valid & ~out_ready;
      hold_q   <= sel;
      if (injected)      in_svc_q <= 1'b1;
      else if (ack_fire) in_svc_q <= 1'b0;
    end
  end

  // R4
  inject_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    injected |=> in_svc_q);

  // R5
  inject_on_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    injected |-> (fetch_valid && out_ready));

  // R6
  no_reinject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_svc_q |-> !injected);

  // R7
  ack_ends_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && in_svc_q) |=> !in_svc_q);

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !out_ready) |=> (!fetch_valid || sel == $past(sel)));

endmodule

// File: rtl/irq_word_mux.sv
module irq_word_mux #(
  parameter int WORD_W = 20,
  parameter logic [WORD_W-1:0] CALL_WORD = '0
) (
  input  logic              sel,
  input  logic [WORD_W-1:0] fetched_word,
  output logic [WORD_W-1:0] out_word
);

  assign out_word = sel ? CALL_WORD : fetched_word;

endmodule

// File: rtl/irq_inject_ctrl.sv
module irq_inject_ctrl
  import irq_inject_pkg::*;
#(
  parameter int WORD_W = WORD_W_DEF,
  parameter int NSRC   = NSRC_DEF,
  parameter logic [OP_W_DEF-1:0] CALL_OP = 5'b11010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  output logic              fetch_ready,
  input  logic [WORD_W-1:0] fetched_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word,
  output logic              injected,
  input  logic [NSRC-1:0]   irq,
  input  logic [NSRC-1:0]   addr,
  input  logic              wr,
  input  logic              rd,
  output logic [NSRC-1:0]   rdata
);

  localparam int TGT_W = WORD_W - OP_W_DEF;
  localparam logic [WORD_W-1:0] CALL_WORD = {CALL_OP, {TGT_W{1'b0}}};

  logic pending;
  logic sel;
  logic ack_fire;

  assign fetch_ready = out_ready;
  assign out_valid   = fetch_valid;

  irq_cause_reg #(.NSRC(NSRC)) i_cause (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq      (irq),
    .ack_fire (ack_fire),
    .ack_mask (addr),
    .rd       (rd),
    .rdata    (rdata),
    .pending  (pending)
  );

  irq_fetch_gate i_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_valid (fetch_valid),
    .out_ready   (out_ready),
    .pending     (pending),
    .wr          (wr),
    .sel         (sel),
    .injected    (injected),
    .ack_fire    (ack_fire)
  );

  irq_word_mux #(.WORD_W(WORD_W), .CALL_WORD(CALL_WORD)) i_mux (
    .sel          (sel),
    .fetched_word (fetched_word),
    .out_word     (out_word)
  );

  // R2
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !injected && !sel |-> out_word == fetched_word);

endmodule

// File: tb/test_irq_inject_ctrl.sv
module test_irq_inject_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fetch_valid, out_ready, wr, rd;
  logic        fetch_ready, out_valid, injected;
  logic [19:0] fetched_word, out_word;
  logic [2:0]  irq, addr, rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [19:0] CALL = 20'hD0000;

  always #5 clk = ~clk;

  irq_inject_ctrl i_irq_inject_ctrl (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .fetched_word(fetched_word), .out_valid(out_valid), .out_ready(out_ready),
    .out_word(out_word), .injected(injected), .irq(irq), .addr(addr),
    .wr(wr), .rd(rd), .rdata(rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [19:0] act, input logic [19:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic read_chk(input logic [2:0] exp, input string req);
    rd = 1'b1; #1;
    chk(rdata == exp, req, {17'd0, rdata}, {17'd0, exp});
    rd = 1'b0; #1;
  endtask

  task automatic fetch(input logic [19:0] w, input bit exp_inj, input string req);
    fetch_valid = 1'b1; out_ready = 1'b1; fetched_word = w; #1;
    chk(out_word == (exp_inj ? CALL : w), req, out_word, exp_inj ? CALL : w);
    chk(injected == exp_inj, req, {19'd0, injected}, {19'd0, exp_inj});
    tick();
    fetch_valid = 1'b0;
  endtask

  task automatic write(input logic [2:0] m, input logic [2:0] req_lvl);
    wr = 1'b1; addr = m; irq = req_lvl;
    tick();
    wr = 1'b0; addr = '0; irq = '0;
  endtask

  initial begin
    rst_n = 1'b0; fetch_valid = 0; out_ready = 0; wr = 0; rd = 0;
    fetched_word = '0; irq = '0; addr = '0;
    repeat (3) tick();
    rst_n = 1'b1; #1;
    // R1 reset state
    read_chk(3'b000, "R1");
    chk(injected == 1'b0, "R1", {19'd0, injected}, 20'd0);
    // R2 pass-through with handshake mirroring
    fetch_valid = 1'b1; out_ready = 1'b0; fetched_word = 20'h5A5A5; #1;
    chk(fetch_ready == 1'b0 && out_valid == 1'b1, "R2", {18'd0, fetch_ready, out_valid}, 20'd1);
    out_ready = 1'b1; #1;
    chk(fetch_ready == 1'b1, "R2", {19'd0, fetch_ready}, 20'd1);
    tick(); fetch_valid = 1'b0;
    fetch(20'h12345, 1'b0, "R2");

    // Sweep every request pattern against every clear mask
    for (int p = 1; p < 8; p++) begin
      for (int m = 0; m < 8; m++) begin
        logic [2:0] rem;
        rem = 3'(p) & ~3'(m);
        irq = 3'(p); tick(); irq = '0;
        // R3 sticky flags and read port
        repeat (2) tick();
        read_chk(3'(p), "R3");
        // R5 no fetch, no injection
        chk(injected == 1'b0, "R5", {19'd0, injected}, 20'd0);
        fetch(20'(p * 4099 + m), 1'b1, "R4");
        // R6 no second injection while in service
        fetch(20'(m * 777 + 3), 1'b0, "R6");
        write(3'(m), 3'b000);
        // R7 selective clear
        read_chk(rem, "R7");
        // R8 second write ignored
        write(3'b111, 3'b000);
        read_chk(rem, "R8");
        if (rem != 0) begin
          // R10 next fetch injects again
          fetch(20'h0ABCD, 1'b1, "R10");
          write(3'b111, 3'b000);
        end
        read_chk(3'b000, "R7");
      end
    end

    // R9 request held on the clearing cycle
    irq = 3'b001; tick(); irq = '0;
    fetch(20'h11111, 1'b1, "R4");
    write(3'b001, 3'b001);
    read_chk(3'b001, "R9");
    // Acknowledge on the same cycle as an accepted fetch
    fetch(20'h22222, 1'b1, "R10");
    wr = 1'b1; addr = 3'b000; fetch_valid = 1'b1; out_ready = 1'b1; fetched_word = 20'h33333; #1;
    chk(out_word == 20'h33333 && !injected, "R6", out_word, 20'h33333);
    tick(); wr = 1'b0; fetch_valid = 1'b0;
    fetch(20'h44444, 1'b1, "R10");
    write(3'b111, 3'b000);
    read_chk(3'b000, "R7");

    // R11 stall holds the pass choice while a request arrives
    fetch_valid = 1'b1; out_ready = 1'b0; fetched_word = 20'h76543; irq = 3'b100; #1;
    chk(out_word == 20'h76543, "R11", out_word, 20'h76543);
    tick(); irq = '0;
    chk(out_word == 20'h76543 && !injected, "R11", out_word, 20'h76543);
    tick();
    chk(out_word == 20'h76543, "R11", out_word, 20'h76543);
    out_ready = 1'b1; #1;
    chk(out_word == 20'h76543 && !injected, "R11", out_word, 20'h76543);
    tick(); fetch_valid = 1'b0;
    fetch(20'h00001, 1'b1, "R11");
    write(3'b100, 3'b000);
    read_chk(3'b000, "R7");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 20'd0, 20'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule